// File: doc/BRIEF.md
# Context-Cache Invalidation Request Decoder

This block sits between the invalidation front end of an address-translation unit and its context cache. It takes two kinds of request. The first is a 128-bit invalidation descriptor, as a queue engine pops it. The second is a 64-bit write to the context command register. For each request it checks the type and the reserved bits. It then extracts the domain, source and function-mask fields and maps the requested granularity onto the two flush operations the context cache supports: flush everything, or flush the entries of one source ID under a function mask.

A domain-selective request has no cheaper form here and is serviced as a full flush. A descriptor that is malformed is rejected before any flush is issued. A descriptor of another type passes by with no effect, and the queue engine learns this from a separate flag.

All results are registered. They appear in the cycle after the request is sampled, as single-cycle pulses. A register write also returns the granularity actually performed, placed where the command register reports it.

Top module: `ccinv_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is 0, even when a valid request is presented.
- R2: A descriptor whose type field (lo bits 3:0) differs from the context-cache type code (default 1) raises desc_done_o and desc_foreign_o for one cycle. It issues no invalidate and no error, even when its reserved bits are set.
- R3: A context-cache descriptor with any lo bit under mask 0xfffc00000000ffc0 set, or with a non-zero hi word, raises desc_done_o and desc_err_o and issues no invalidate.
- R4: A context-cache descriptor with granularity field lo bits 5:4 equal to 0 raises desc_err_o and issues no invalidate.
- R5: A valid descriptor with granularity 1 (global) or 2 (domain) pulses inv_global_o, with inv_did_o taken from lo bits 31:16 and inv_sid_o and inv_fm_o at 0.
- R6: A valid descriptor with granularity 3 (device) pulses inv_device_o, with inv_sid_o from lo bits 47:32, inv_fm_o from lo bits 49:48 and inv_did_o at 0.
- R7: Each result appears exactly one clock after its request is sampled and lasts one cycle. At most one of inv_global_o, inv_device_o and desc_err_o is high in any cycle.
- R8: A command write decodes its granularity from bits 62:61. Values 1 and 2 pulse inv_global_o with inv_did_o from bits 15:0. Value 3 pulses inv_device_o with inv_sid_o from bits 31:16 and inv_fm_o from bits 33:32. Value 0 issues nothing.
- R9: A command write pulses resp_valid_o. resp_o then carries the actual granularity in bits 60:59 (1 for global or domain, 3 for device, 0 for invalid), and all its other bits are 0.
- R10: When a descriptor and a command arrive in the same cycle, the descriptor is serviced and the command is dropped, so resp_valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| desc_valid_i | input | 1 | Descriptor present this cycle |
| desc_lo_i | input | 64 | Descriptor low word |
| desc_hi_i | input | 64 | Descriptor high word |
| cmd_valid_i | input | 1 | Command register write this cycle |
| cmd_data_i | input | 64 | Command register write data |
| inv_global_o | output | 1 | Flush-all pulse to the context cache |
| inv_device_o | output | 1 | Device-selective flush pulse |
| inv_did_o | output | 16 | Domain ID that accompanies a flush-all |
| inv_sid_o | output | 16 | Source ID for a device flush |
| inv_fm_o | output | 2 | Function mask for a device flush |
| desc_done_o | output | 1 | A descriptor was consumed |
| desc_err_o | output | 1 | The consumed descriptor was malformed |
| desc_foreign_o | output | 1 | The consumed descriptor was of another type |
| resp_valid_o | output | 1 | Command result valid |
| resp_o | output | 64 | Command read-back with actual granularity |

## Verification
The assertions assume that the request inputs carry no unknown bits while their valid is high. The reserved-rejection and device-field properties also assume the default priority, which lets a descriptor win a collision. The stimulus holds each valid for exactly one cycle and idles all fields at zero between requests. It presents both request kinds together only in one directed collision case. In that case the expected result is the descriptor's alone.

// File: rtl/ccinv_pkg.sv
`timescale 1ns/1ps
package ccinv_pkg;

   localparam int unsigned WORD_W = 64;
   localparam int unsigned ID_W   = 16;
   localparam int unsigned FM_W   = 2;

   // descriptor low-word layout
   localparam int unsigned D_GRAN_LSB = 4;
   localparam int unsigned D_DID_LSB  = 16;
   localparam int unsigned D_SID_LSB  = 32;
   localparam int unsigned D_FM_LSB   = 48;
   localparam logic [WORD_W-1:0] CC_RSVD_MASK = 64'hfffc_0000_0000_ffc0;

   // command register layout
   localparam int unsigned C_DID_LSB  = 0;
   localparam int unsigned C_SID_LSB  = 16;
   localparam int unsigned C_FM_LSB   = 32;
   localparam int unsigned C_GRAN_LSB = 61;
   localparam int unsigned CAIG_LSB   = 59;
   localparam logic [WORD_W-1:0] CAIG_MASK = 64'h3 << CAIG_LSB;

   typedef enum logic [1:0] {
      GR_NONE   = 2'd0,
      GR_GLOBAL = 2'd1,
      GR_DOMAIN = 2'd2,
      GR_DEVICE = 2'd3
   } gran_e;

   typedef struct packed {
      logic            glob;
      logic            dev;
      logic            err;
      logic            foreign;
      logic [ID_W-1:0] did;
      logic [ID_W-1:0] sid;
      logic [FM_W-1:0] fm;
      logic [1:0]      caig;
   } dec_res_t;

   function automatic logic [WORD_W-1:0] place_caig(input logic [1:0] g);
      return WORD_W'(g) << CAIG_LSB;
   endfunction

endpackage

// File: rtl/ccinv_desc_dec.sv
`timescale 1ns/1ps
module ccinv_desc_dec
   import ccinv_pkg::*;
#(
   parameter int unsigned CC_TYPE = 1
) (
   input  logic [WORD_W-1:0] lo_i,
   input  logic [WORD_W-1:0] hi_i,
   output dec_res_t          res_o
);

   logic [WORD_W-1:0] rsvd_hit;
   logic              type_match;
   gran_e             gran;

   for (genvar b = 0; b < WORD_W; b++) begin : g_rsvd
      if (CC_RSVD_MASK[b]) begin : g_chk
         assign rsvd_hit[b] = lo_i[b];
      end else begin : g_free
         assign rsvd_hit[b] = 1'b0;
      end
   end

   assign type_match = (lo_i[3:0] == 4'(CC_TYPE));
   assign gran       = gran_e'(lo_i[D_GRAN_LSB +: 2]);

   always_comb begin
      res_o = '0;
      if (!type_match) begin
         res_o.foreign = 1'b1;
      end else if ((|rsvd_hit) || (|hi_i)) begin
         res_o.err = 1'b1;
      end else begin
         case (gran)
            GR_GLOBAL, GR_DOMAIN: begin
               res_o.glob = 1'b1;
               res_o.did  = lo_i[D_DID_LSB +: ID_W];
            end
            GR_DEVICE: begin
               res_o.dev = 1'b1;
               res_o.sid = lo_i[D_SID_LSB +: ID_W];
               res_o.fm  = lo_i[D_FM_LSB +: FM_W];
            end
            default: res_o.err = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/ccinv_cmd_dec.sv
`timescale 1ns/1ps
module ccinv_cmd_dec
   import ccinv_pkg::*;
(
   input  logic [WORD_W-1:0] cmd_i,
   output dec_res_t          res_o
);

   gran_e gran;
   logic  unused_cmd_bits;

   assign gran            = gran_e'(cmd_i[C_GRAN_LSB +: 2]);
   assign unused_cmd_bits = ^{cmd_i[63], cmd_i[60:34]};

   always_comb begin
      res_o = '0;
      case (gran)
         GR_GLOBAL, GR_DOMAIN: begin
            res_o.glob = 1'b1;
            res_o.did  = cmd_i[C_DID_LSB +: ID_W];
            res_o.caig = 2'd1;
         end
         GR_DEVICE: begin
            res_o.dev  = 1'b1;
            res_o.sid  = cmd_i[C_SID_LSB +: ID_W];
            res_o.fm   = cmd_i[C_FM_LSB +: FM_W];
            res_o.caig = 2'd3;
         end
         default: res_o.caig = 2'd0;
      endcase
   end

endmodule

// File: rtl/ccinv_issue.sv
`timescale 1ns/1ps
module ccinv_issue
   import ccinv_pkg::*;
#(
   parameter int unsigned DESC_FIRST = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              desc_v_i,
   input  logic              cmd_v_i,
   input  dec_res_t          desc_res_i,
   input  dec_res_t          cmd_res_i,
   output logic              inv_global_o,
   output logic              inv_device_o,
   output logic [ID_W-1:0]   inv_did_o,
   output logic [ID_W-1:0]   inv_sid_o,
   output logic [FM_W-1:0]   inv_fm_o,
   output logic              desc_done_o,
   output logic              desc_err_o,
   output logic              desc_foreign_o,
   output logic              resp_valid_o,
   output logic [WORD_W-1:0] resp_o
);

   logic     take_desc;
   logic     take_cmd;
   dec_res_t sel;

   if (DESC_FIRST != 0) begin : g_desc_wins
      assign take_desc = desc_v_i;
      assign take_cmd  = cmd_v_i & ~desc_v_i;
   end else begin : g_cmd_wins
      assign take_cmd  = cmd_v_i;
      assign take_desc = desc_v_i & ~cmd_v_i;
   end

   always_comb begin
      sel = '0;
      if (take_desc)     sel = desc_res_i;
      else if (take_cmd) sel = cmd_res_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         inv_global_o   <= 1'b0;
         inv_device_o   <= 1'b0;
         inv_did_o      <= '0;
         inv_sid_o      <= '0;
         inv_fm_o       <= '0;
         desc_done_o    <= 1'b0;
         desc_err_o     <= 1'b0;
         desc_foreign_o <= 1'b0;
         resp_valid_o   <= 1'b0;
         resp_o         <= '0;
      end else begin
         inv_global_o   <= sel.glob;
         inv_device_o   <= sel.dev;
         inv_did_o      <= sel.did;
         inv_sid_o      <= sel.sid;
         inv_fm_o       <= sel.fm;
         desc_done_o    <= take_desc;
         desc_err_o     <= take_desc & sel.err;
         desc_foreign_o <= take_desc & sel.foreign;
         resp_valid_o   <= take_cmd;
         resp_o         <= take_cmd ? place_caig(sel.caig) : '0;
      end
   end

   AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({inv_global_o, inv_device_o, desc_err_o})); // R7

   AST_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inv_global_o || inv_device_o || desc_done_o || resp_valid_o)
         |-> $past(desc_v_i || cmd_v_i)); // R7

endmodule

// File: rtl/ccinv_top.sv
`timescale 1ns/1ps
module ccinv_top
   import ccinv_pkg::*;
#(
   parameter int unsigned DESC_CC_TYPE = 1,
   parameter int unsigned DESC_FIRST   = 1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        desc_valid_i,
   input  logic [63:0] desc_lo_i,
   input  logic [63:0] desc_hi_i,
   input  logic        cmd_valid_i,
   input  logic [63:0] cmd_data_i,
   output logic        inv_global_o,
   output logic        inv_device_o,
   output logic [15:0] inv_did_o,
   output logic [15:0] inv_sid_o,
   output logic [1:0]  inv_fm_o,
   output logic        desc_done_o,
   output logic        desc_err_o,
   output logic        desc_foreign_o,
   output logic        resp_valid_o,
   output logic [63:0] resp_o
);

   if (DESC_CC_TYPE > 15) begin : g_bad_type
      $error("DESC_CC_TYPE does not fit the 4-bit descriptor type field");
   end
   if (DESC_FIRST > 1) begin : g_bad_prio
      $error("DESC_FIRST must be 0 or 1");
   end

   dec_res_t desc_res;
   dec_res_t cmd_res;

   ccinv_desc_dec #(.CC_TYPE(DESC_CC_TYPE)) i_desc_dec (
      .lo_i  (desc_lo_i),
      .hi_i  (desc_hi_i),
      .res_o (desc_res)
   );

   ccinv_cmd_dec i_cmd_dec (
      .cmd_i (cmd_data_i),
      .res_o (cmd_res)
   );

   ccinv_issue #(.DESC_FIRST(DESC_FIRST)) i_issue (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .desc_v_i       (desc_valid_i),
      .cmd_v_i        (cmd_valid_i),
      .desc_res_i     (desc_res),
      .cmd_res_i      (cmd_res),
      .inv_global_o   (inv_global_o),
      .inv_device_o   (inv_device_o),
      .inv_did_o      (inv_did_o),
      .inv_sid_o      (inv_sid_o),
      .inv_fm_o       (inv_fm_o),
      .desc_done_o    (desc_done_o),
      .desc_err_o     (desc_err_o),
      .desc_foreign_o (desc_foreign_o),
      .resp_valid_o   (resp_valid_o),
      .resp_o         (resp_o)
   );

   logic desc_owns;
   logic desc_typed;
   logic desc_clean;
   assign desc_owns  = desc_valid_i && ((DESC_FIRST != 0) || !cmd_valid_i);
   assign desc_typed = desc_lo_i[3:0] == 4'(DESC_CC_TYPE);
   assign desc_clean = ((desc_lo_i & CC_RSVD_MASK) == '0) && (desc_hi_i == '0);

   AST_FOREIGN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (desc_owns && !desc_typed)
         |=> (desc_foreign_o && !desc_err_o && !inv_global_o && !inv_device_o)); // R2

   AST_RSVD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (desc_owns && desc_typed && !desc_clean)
         |=> (desc_err_o && !inv_global_o && !inv_device_o)); // R3

   AST_DEV_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (desc_owns && desc_typed && desc_clean && desc_lo_i[5:4] == 2'd3)
         |=> (inv_device_o && inv_sid_o == $past(desc_lo_i[47:32])
              && inv_fm_o == $past(desc_lo_i[49:48]))); // R6

   AST_RESP_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_valid_o |-> (((resp_o & ~CAIG_MASK) == '0) && resp_o[60:59] != 2'd2)); // R9

   AST_COLLIDE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (desc_valid_i && cmd_valid_i && DESC_FIRST != 0) |=> !resp_valid_o); // R10

endmodule

// File: tb/test_ccinv_top.sv
`timescale 1ns/1ps
module test_ccinv_top;

   typedef struct packed {
      logic        g;
      logic        d;
      logic [15:0] did;
      logic [15:0] sid;
      logic [1:0]  fm;
      logic        done;
      logic        err;
      logic        fgn;
      logic        rv;
      logic [63:0] resp;
   } obs_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        desc_valid;
   logic [63:0] desc_lo;
   logic [63:0] desc_hi;
   logic        cmd_valid;
   logic [63:0] cmd_data;
   logic        inv_global, inv_device, desc_done, desc_err, desc_foreign, resp_valid;
   logic [15:0] inv_did, inv_sid;
   logic [1:0]  inv_fm;
   logic [63:0] resp;

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   ccinv_top i_ccinv_top (
      .clk_i(clk), .rst_ni(rst_n),
      .desc_valid_i(desc_valid), .desc_lo_i(desc_lo), .desc_hi_i(desc_hi),
      .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data),
      .inv_global_o(inv_global), .inv_device_o(inv_device),
      .inv_did_o(inv_did), .inv_sid_o(inv_sid), .inv_fm_o(inv_fm),
      .desc_done_o(desc_done), .desc_err_o(desc_err), .desc_foreign_o(desc_foreign),
      .resp_valid_o(resp_valid), .resp_o(resp)
   );

   // {is_cmd, word_a, word_b}
   localparam logic [128:0] VEC [16] = '{
      {1'b0, 64'h0000_0000_1234_0011, 64'h0},
      {1'b0, 64'h0000_0000_ABCD_0021, 64'h0},
      {1'b0, 64'h0003_5A5A_0000_0031, 64'h0},
      {1'b0, 64'h0001_0102_0000_0031, 64'h0},
      {1'b0, 64'h0000_0000_0000_0001, 64'h0},
      {1'b0, 64'h0000_0000_0000_0051, 64'h0},
      {1'b0, 64'h8000_0000_0000_0011, 64'h0},
      {1'b0, 64'h0004_0000_0000_0011, 64'h0},
      {1'b0, 64'h0000_0000_0000_0011, 64'h1},
      {1'b0, 64'h0000_0000_0000_0012, 64'h0},
      {1'b0, 64'hFFFF_0000_0000_FFF5, 64'h7},
      {1'b1, 64'h2000_0000_0000_0042, 64'h0},
      {1'b1, 64'h4000_0000_0000_0777, 64'h0},
      {1'b1, 64'h6000_0002_BEEF_0000, 64'h0},
      {1'b1, 64'h0000_0001_1111_2222, 64'h0},
      {1'b1, 64'hA000_0000_0000_0009, 64'h0}
   };

   function automatic obs_t model(input logic is_cmd, input logic [63:0] a,
                                  input logic [63:0] h, output string tag);
      obs_t e = '0;
      if (!is_cmd) begin
         e.done = 1'b1;
         if (a[3:0] != 4'h1) begin
            e.fgn = 1'b1; tag = "R2";
         end else if ((a & 64'hfffc_0000_0000_ffc0) != 0 || h != 0) begin
            e.err = 1'b1; tag = "R3";
         end else if (a[5:4] == 2'd0) begin
            e.err = 1'b1; tag = "R4";
         end else if (a[5:4] == 2'd3) begin
            e.d = 1'b1; e.sid = a[47:32]; e.fm = a[49:48]; tag = "R6";
         end else begin
            e.g = 1'b1; e.did = a[31:16]; tag = "R5";
         end
      end else begin
         e.rv = 1'b1;
         tag = "R8/R9";
         case (a[62:61])
            2'd1, 2'd2: begin e.g = 1'b1; e.did = a[15:0]; e.resp = 64'h1 << 59; end
            2'd3: begin e.d = 1'b1; e.sid = a[31:16]; e.fm = a[33:32]; e.resp = 64'h3 << 59; end
            default: e.resp = 64'h0;
         endcase
      end
      return e;
   endfunction

   function automatic obs_t sample();
      return '{g: inv_global, d: inv_device, did: inv_did, sid: inv_sid, fm: inv_fm,
               done: desc_done, err: desc_err, fgn: desc_foreign, rv: resp_valid,
               resp: resp};
   endfunction

   task automatic check(input string tag, input obs_t exp);
      obs_t act = sample();
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      desc_valid = 1'b0; desc_lo = '0; desc_hi = '0;
      cmd_valid  = 1'b0; cmd_data = '0;
   endtask

   task automatic run_one(input logic is_cmd, input logic [63:0] a, input logic [63:0] h);
      string tag;
      obs_t  e;
      e = model(is_cmd, a, h, tag);
      @(negedge clk);
      if (is_cmd) begin cmd_valid = 1'b1; cmd_data = a; end
      else begin desc_valid = 1'b1; desc_lo = a; desc_hi = h; end
      @(negedge clk);
      idle_inputs();
      check(tag, e);
      @(negedge clk);
      check("R7 pulse ended", '0);
   endtask

   initial begin
      string tag;
      obs_t  e;
      rst_n = 1'b0;
      idle_inputs();
      // R1: requests during reset produce nothing
      @(negedge clk);
      desc_valid = 1'b1; desc_lo = 64'h0000_0000_1234_0011;
      cmd_valid = 1'b1;  cmd_data = 64'h6000_0002_BEEF_0000;
      @(negedge clk);
      check("R1 request in reset", '0);
      idle_inputs();
      @(negedge clk);
      check("R1 reset state", '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", '0);

      for (int i = 0; i < 16; i++)
         run_one(VEC[i][128], VEC[i][127:64], VEC[i][63:0]);

      // R10: collision, descriptor wins, command dropped
      e = model(1'b0, 64'h0002_0777_0000_0031, 64'h0, tag);
      @(negedge clk);
      desc_valid = 1'b1; desc_lo = 64'h0002_0777_0000_0031;
      cmd_valid = 1'b1;  cmd_data = 64'h2000_0000_0000_0055;
      @(negedge clk);
      idle_inputs();
      check("R10 collision", e);

      // R7: back-to-back requests each give their own single pulse
      @(negedge clk);
      desc_valid = 1'b1; desc_lo = 64'h0000_0000_0001_0011;
      @(negedge clk);
      desc_valid = 1'b0; desc_lo = '0;
      cmd_valid = 1'b1;  cmd_data = 64'h6000_0001_00A0_0000;
      e = model(1'b0, 64'h0000_0000_0001_0011, 64'h0, tag);
      check("R7 first of pair", e);
      @(negedge clk);
      idle_inputs();
      e = model(1'b1, 64'h6000_0001_00A0_0000, 64'h0, tag);
      check("R7 second of pair", e);
      @(negedge clk);
      check("R7 pair ended", '0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL R7 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule